// File: doc/BRIEF.md
# Power-domain vote engine

This block takes power-on and power-off votes for a group of switchable power domains over a simple word-addressed register bus. It then carries out each requested transition by itself. Every domain owns one bit position, and that position is the same in all the command and status registers. A vote moves the domain through a short preparation phase and then drives a request line toward a power switch. The engine waits for the switch acknowledge, and for a power-off it also waits a fixed settling window. Only then does it report the domain idle again.

Software starts a command by writing a one into the domain's bit of the power-on or power-off command register. It reads the command bit back to see that the engine has picked the vote up. It then polls the status registers until the completion rule for that direction holds. Each domain has at most one command in flight. A command for a domain that is still busy is dropped, and a sticky error bit for that domain is raised.

Top module: `pwr_vote_engine`

## Requirements
- R1: After reset every domain is idle. The idle register (offset 3) reads all ones, and the on-command read-back (offset 0) reads all ones. The off-command read-back (offset 1), the enabled register (offset 2), both pending registers (offsets 4 and 5), the error register (offset 6) and every switch request read zero. The error register is cleared only by reset.
- R2: Domain i is controlled and reported by bit i of every register. Bits at or above the domain count read zero. A command changes no other domain's state.
- R3: Writing one to a domain's bit at offset 0 (power-on) makes that bit read 0 on the next cycle. The bit reads 1 again once the engine has left its preparation phase and is driving the switch.
- R4: Writing one to a domain's bit at offset 1 (power-off) leaves that bit reading 1 while the command is being prepared. The bit reads 0 once the engine is driving the switch.
- R5: While a power-on is in progress the domain reads 0 at offset 3 and 1 at offset 4. While a power-off is in progress it reads 0 at offset 3 and 1 at offset 5. The two pending bits are never 1 together.
- R6: A power-on is complete when the domain reads 1 at offsets 3 and 2 and 0 at offset 4. This happens only after the switch acknowledge has risen, and the request stays 1 afterwards.
- R7: A power-off drops the switch request. It is complete when the domain reads 1 at offset 3 and 0 at offset 5, and that takes at least SETTLE_CYC cycles after the engine starts driving the switch.
- R8: The enabled bit (offset 2) changes only when a transition completes. It does not change when a command is accepted or while one is running.
- R9: A command written for a domain that is not idle has no effect on that domain's transition, request or enabled bit. It sets that domain's sticky error bit at offset 6.
- R10: An accepted command starts within START_LIMIT cycles and completes within FINISH_LIMIT cycles when the switch answers promptly.
- R11: One write whose mask covers both idle and busy domains starts the idle domains and rejects the busy ones in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Word offset of the register |
| bus_wdata | input | DATA_W | Write data, one bit per domain |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| sw_req | output | NUM_DOM | Per-domain power request toward the switch |
| sw_ack | input | NUM_DOM | Per-domain power acknowledge from the switch |

## Verification
Acceptance and rejection can fall in the same clock edge. This happens when one command write carries a mask in which some domains are idle and others are still mid-transition. The bench provokes it by issuing a second power-on write one cycle after the first, with a mask that covers the busy domain and a fresh idle one. It judges the result from the error bits, the pending bits and the final enabled pattern. A busy domain's rejected vote is also overlapped with its own running power-off, and the bench confirms that the request and the enabled bit still follow the original command.

// File: rtl/pve_pkg.sv
package pve_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ON_PREP,
      ST_ON_RUN,
      ST_OFF_PREP,
      ST_OFF_RUN,
      ST_OFF_SETTLE
   } dom_state_e;

   // Register word offsets
   localparam int unsigned OFS_SET     = 0;
   localparam int unsigned OFS_CLR     = 1;
   localparam int unsigned OFS_EN      = 2;
   localparam int unsigned OFS_DONE    = 3;
   localparam int unsigned OFS_SET_STA = 4;
   localparam int unsigned OFS_CLR_STA = 5;
   localparam int unsigned OFS_ERR     = 6;
   localparam int unsigned OFS_LAST    = OFS_ERR;

endpackage

// File: rtl/pve_ack_sync.sv
module pve_ack_sync #(
   parameter int unsigned WIDTH  = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] ack_in,
   output logic [WIDTH-1:0] ack_out
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign ack_out = ack_in;
      end else begin : g_chain
         logic [WIDTH-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int k = 0; k < STAGES; k++) stg[k] <= '0;
            end else begin
               stg[0] <= ack_in;
               for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
            end
         end
         assign ack_out = stg[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/pve_regbus.sv
module pve_regbus
   import pve_pkg::*;
#(
   parameter int unsigned NUM_DOM = 4,
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned DATA_W  = 32
) (
   input  logic               bus_we,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic [NUM_DOM-1:0] set_stb,
   output logic [NUM_DOM-1:0] clr_stb,
   input  logic [NUM_DOM-1:0] set_rb,
   input  logic [NUM_DOM-1:0] clr_rb,
   input  logic [NUM_DOM-1:0] en_v,
   input  logic [NUM_DOM-1:0] done_v,
   input  logic [NUM_DOM-1:0] set_sta_v,
   input  logic [NUM_DOM-1:0] clr_sta_v,
   input  logic [NUM_DOM-1:0] err_v
);

   logic hit_set;
   logic hit_clr;
   logic [NUM_DOM-1:0] rd_sel;

   assign hit_set = bus_we && (bus_addr == ADDR_W'(OFS_SET));
   assign hit_clr = bus_we && (bus_addr == ADDR_W'(OFS_CLR));
   assign set_stb = hit_set ? bus_wdata[NUM_DOM-1:0] : '0;
   assign clr_stb = hit_clr ? bus_wdata[NUM_DOM-1:0] : '0;

   always_comb begin
      case (bus_addr)
         ADDR_W'(OFS_SET):     rd_sel = set_rb;
         ADDR_W'(OFS_CLR):     rd_sel = clr_rb;
         ADDR_W'(OFS_EN):      rd_sel = en_v;
         ADDR_W'(OFS_DONE):    rd_sel = done_v;
         ADDR_W'(OFS_SET_STA): rd_sel = set_sta_v;
         ADDR_W'(OFS_CLR_STA): rd_sel = clr_sta_v;
         ADDR_W'(OFS_ERR):     rd_sel = err_v;
         default:              rd_sel = '0;
      endcase
   end

   generate
      if (NUM_DOM == DATA_W) begin : g_full
         assign bus_rdata = rd_sel;
      end else begin : g_pad
         assign bus_rdata = {{(DATA_W-NUM_DOM){1'b0}}, rd_sel};
      end
   endgenerate

endmodule

// File: rtl/pve_dom_fsm.sv
module pve_dom_fsm
   import pve_pkg::*;
#(
   parameter int unsigned START_DLY  = 4,
   parameter int unsigned SETTLE_CYC = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_stb,
   input  logic clr_stb,
   input  logic ack,
   output logic req,
   output logic en,
   output logic done,
   output logic set_sta,
   output logic clr_sta,
   output logic set_rb,
   output logic clr_rb,
   output logic err
);

   localparam int unsigned CNT_MAX = (START_DLY > SETTLE_CYC) ? START_DLY : SETTLE_CYC;
   localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
   localparam logic [CNT_W-1:0] PREP_LD   = CNT_W'(START_DLY - 1);
   localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC - 1);

   dom_state_e       st_q;
   logic [CNT_W-1:0] cnt_q;
   logic             cnt_zero;

   assign cnt_zero = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
         req   <= 1'b0;
         en    <= 1'b0;
         err   <= 1'b0;
      end else begin
         if ((set_stb || clr_stb) && (st_q != ST_IDLE)) err <= 1'b1;
         case (st_q)
            ST_IDLE: begin
               if (set_stb) begin
                  st_q  <= ST_ON_PREP;
                  cnt_q <= PREP_LD;
               end else if (clr_stb) begin
                  st_q  <= ST_OFF_PREP;
                  cnt_q <= PREP_LD;
               end
            end
            ST_ON_PREP: begin
               if (cnt_zero) begin
                  st_q <= ST_ON_RUN;
                  req  <= 1'b1;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            ST_ON_RUN: begin
               if (ack) begin
                  st_q <= ST_IDLE;
                  en   <= 1'b1;
               end
            end
            ST_OFF_PREP: begin
               if (cnt_zero) begin
                  st_q <= ST_OFF_RUN;
                  req  <= 1'b0;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            ST_OFF_RUN: begin
               if (!ack) begin
                  st_q  <= ST_OFF_SETTLE;
                  cnt_q <= SETTLE_LD;
               end
            end
            ST_OFF_SETTLE: begin
               if (cnt_zero) begin
                  st_q <= ST_IDLE;
                  en   <= 1'b0;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign done    = (st_q == ST_IDLE);
   assign set_sta = (st_q == ST_ON_PREP) || (st_q == ST_ON_RUN);
   assign clr_sta = (st_q == ST_OFF_PREP) || (st_q == ST_OFF_RUN) || (st_q == ST_OFF_SETTLE);
   // On-command read-back drops only while preparing; off-command read-back is high only while preparing
   assign set_rb  = (st_q != ST_ON_PREP);
   assign clr_rb  = (st_q == ST_OFF_PREP);

endmodule

// File: rtl/pwr_vote_engine.sv
module pwr_vote_engine
   import pve_pkg::*;
#(
   parameter int unsigned NUM_DOM         = 4,
   parameter int unsigned ADDR_W          = 4,
   parameter int unsigned DATA_W          = 32,
   parameter int unsigned START_DLY       = 4,
   parameter int unsigned SETTLE_CYC      = 12,
   parameter int unsigned ACK_SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_we,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic [NUM_DOM-1:0] sw_req,
   input  logic [NUM_DOM-1:0] sw_ack
);

   generate
      if (NUM_DOM < 1 || NUM_DOM > DATA_W) begin : g_bad_dom
         $error("NUM_DOM must lie between 1 and DATA_W");
      end
      if ((1 << ADDR_W) <= OFS_LAST) begin : g_bad_addr
         $error("ADDR_W too narrow for the register map");
      end
      if (START_DLY < 1 || SETTLE_CYC < 1) begin : g_bad_dly
         $error("START_DLY and SETTLE_CYC must be at least 1");
      end
   endgenerate

   logic [NUM_DOM-1:0] set_stb, clr_stb;
   logic [NUM_DOM-1:0] ack_s;
   logic [NUM_DOM-1:0] dom_en, dom_done, dom_set_sta, dom_clr_sta;
   logic [NUM_DOM-1:0] dom_set_rb, dom_clr_rb, err_q;

   pve_ack_sync #(
      .WIDTH  (NUM_DOM),
      .STAGES (ACK_SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .ack_in  (sw_ack),
      .ack_out (ack_s)
   );

   pve_regbus #(
      .NUM_DOM (NUM_DOM),
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W)
   ) u_bus (
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .set_stb   (set_stb),
      .clr_stb   (clr_stb),
      .set_rb    (dom_set_rb),
      .clr_rb    (dom_clr_rb),
      .en_v      (dom_en),
      .done_v    (dom_done),
      .set_sta_v (dom_set_sta),
      .clr_sta_v (dom_clr_sta),
      .err_v     (err_q)
   );

   generate
      for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
         pve_dom_fsm #(
            .START_DLY  (START_DLY),
            .SETTLE_CYC (SETTLE_CYC)
         ) u_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_stb (set_stb[d]),
            .clr_stb (clr_stb[d]),
            .ack     (ack_s[d]),
            .req     (sw_req[d]),
            .en      (dom_en[d]),
            .done    (dom_done[d]),
            .set_sta (dom_set_sta[d]),
            .clr_sta (dom_clr_sta[d]),
            .set_rb  (dom_set_rb[d]),
            .clr_rb  (dom_clr_rb[d]),
            .err     (err_q[d])
         );
      end
   endgenerate

endmodule

// File: rtl/pve_checker.sv
module pve_checker #(
   parameter int unsigned NUM_DOM = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_DOM-1:0] done_v,
   input logic [NUM_DOM-1:0] set_sta_v,
   input logic [NUM_DOM-1:0] clr_sta_v,
   input logic [NUM_DOM-1:0] en_v,
   input logic [NUM_DOM-1:0] err_v,
   input logic [NUM_DOM-1:0] req_v,
   input logic [NUM_DOM-1:0] ack_v
);

   p_sta_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_sta_v & clr_sta_v) == '0));

   p_busy_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((done_v & (set_sta_v | clr_sta_v)) == '0));

   p_en_at_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(en_v) |-> ((done_v & ~$past(done_v)) != '0));

   p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(err_v) & ~err_v) == '0));

   p_idle_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((done_v & (en_v ^ ack_v)) == '0));

   p_req_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_v == '1) |=> $stable(req_v));

endmodule

bind pwr_vote_engine pve_checker #(.NUM_DOM(NUM_DOM)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .done_v    (dom_done),
   .set_sta_v (dom_set_sta),
   .clr_sta_v (dom_clr_sta),
   .en_v      (dom_en),
   .err_v     (err_q),
   .req_v     (sw_req),
   .ack_v     (ack_s)
);

// File: tb/sim_pwr_vote_engine.sv
`timescale 1ns/1ps
module sim_pwr_vote_engine;

   localparam int NUM_DOM      = 4;
   localparam int ADDR_W       = 4;
   localparam int DATA_W       = 32;
   localparam int START_DLY    = 4;
   localparam int SETTLE_CYC   = 12;
   localparam int ACK_LAT      = 3;
   localparam int START_LIMIT  = 300;
   localparam int FINISH_LIMIT = 3000;

   localparam int A_SET = 0, A_CLR = 1, A_EN = 2, A_DONE = 3;
   localparam int A_SSTA = 4, A_CSTA = 5, A_ERR = 6;

   // Vector table: {is_off, mask[3:0]} and expected enabled pattern after completion
   localparam int NVEC = 6;
   localparam logic [4:0] VEC_CMD [NVEC] = '{5'b0_0001, 5'b0_0100, 5'b1_0001,
                                             5'b0_1010, 5'b1_0110, 5'b1_1000};
   localparam logic [3:0] VEC_EN  [NVEC] = '{4'b0001, 4'b0101, 4'b0100,
                                             4'b1110, 4'b1000, 4'b0000};

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               bus_we = 1'b0;
   logic [ADDR_W-1:0]  bus_addr = '0;
   logic [DATA_W-1:0]  bus_wdata = '0;
   logic [DATA_W-1:0]  bus_rdata;
   logic [NUM_DOM-1:0] sw_req;
   logic [NUM_DOM-1:0] sw_ack;
   logic [NUM_DOM-1:0] ack_pipe [ACK_LAT];

   int n_tests = 0;
   int n_fail  = 0;

   always #5 clk = ~clk;

   pwr_vote_engine #(
      .NUM_DOM (NUM_DOM), .ADDR_W (ADDR_W), .DATA_W (DATA_W),
      .START_DLY (START_DLY), .SETTLE_CYC (SETTLE_CYC), .ACK_SYNC_STAGES (2)
   ) u0 (
      .clk (clk), .rst_n (rst_n), .bus_we (bus_we), .bus_addr (bus_addr),
      .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
      .sw_req (sw_req), .sw_ack (sw_ack)
   );

   // Power switch model: acknowledge follows request after ACK_LAT cycles
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < ACK_LAT; k++) ack_pipe[k] <= '0;
      end else begin
         ack_pipe[0] <= sw_req;
         for (int k = 1; k < ACK_LAT; k++) ack_pipe[k] <= ack_pipe[k-1];
      end
   end
   assign sw_ack = ack_pipe[ACK_LAT-1];

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic rd(input int ofs, output logic [31:0] v);
      bus_addr = ADDR_W'(ofs);
      #1;
      v = bus_rdata;
   endtask

   task automatic wr(input int ofs, input logic [31:0] v);
      @(negedge clk);
      bus_addr  = ADDR_W'(ofs);
      bus_wdata = v;
      bus_we    = 1'b1;
      @(negedge clk);
      bus_we    = 1'b0;
      bus_wdata = '0;
   endtask

   task automatic wait_idle(input logic [3:0] mask, input string rq);
      logic [31:0] v;
      int n;
      n = 0;
      rd(A_DONE, v);
      while (((v[3:0] & mask) != mask) && n < FINISH_LIMIT) begin
         @(negedge clk);
         n++;
         rd(A_DONE, v);
      end
      chk(rq, 32'(n < FINISH_LIMIT), 32'd1);
   endtask

   task automatic do_cmd(input logic is_off, input logic [3:0] mask,
                         input logic [3:0] prev_en, input logic [3:0] exp_en);
      logic [31:0] v, d, e, s;
      int n;
      int bad_en;
      wr(is_off ? A_CLR : A_SET, 32'(mask));
      rd(is_off ? A_CLR : A_SET, v);
      if (is_off) chk("R4 off read-back held high", 32'(v[3:0] & mask), 32'(mask));
      else        chk("R3 on read-back drops",      32'(v[3:0] & mask), 32'd0);
      rd(A_DONE, v);
      chk("R5 idle low while busy", 32'(v[3:0] & mask), 32'd0);
      rd(is_off ? A_CSTA : A_SSTA, v);
      chk("R5 pending high while busy", 32'(v[3:0] & mask), 32'(mask));
      rd(A_EN, v);
      chk("R8 enabled unchanged on accept", v, 32'(prev_en));
      // start
      n = 0;
      rd(is_off ? A_CLR : A_SET, v);
      while (((is_off ? (v[3:0] & mask) != 0 : (v[3:0] & mask) != mask)) && n < START_LIMIT) begin
         @(negedge clk);
         n++;
         rd(is_off ? A_CLR : A_SET, v);
      end
      chk("R10 command started in time", 32'(n < START_LIMIT), 32'd1);
      // completion
      n = 0;
      bad_en = 0;
      forever begin
         rd(A_DONE, d);
         rd(A_EN, e);
         rd(is_off ? A_CSTA : A_SSTA, s);
         if (is_off) begin
            if (((d[3:0] & mask) == mask) && ((s[3:0] & mask) == 0)) break;
            if ((s[3:0] & mask) != 0 && (e[3:0] & mask) != mask) bad_en++;
         end else begin
            if (((d[3:0] & mask) == mask) && ((e[3:0] & mask) == mask) &&
                ((s[3:0] & mask) == 0)) break;
            if ((e[3:0] & mask) != 0) bad_en++;
         end
         if (n >= FINISH_LIMIT) break;
         @(negedge clk);
         n++;
      end
      chk("R10 command finished in time", 32'(n < FINISH_LIMIT), 32'd1);
      chk("R8 enabled held until completion", 32'(bad_en), 32'd0);
      if (is_off) chk("R7 settle window respected", 32'(n >= SETTLE_CYC), 32'd1);
      rd(A_EN, v);
      chk(is_off ? "R7 enabled after power-off" : "R6 enabled after power-on", v, 32'(exp_en));
      chk("R6 switch request pattern", 32'(sw_req), 32'(exp_en));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] v;
      logic [3:0]  cur_en;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd(A_SET, v);  chk("R1 on read-back after reset", v, 32'hF);
      rd(A_CLR, v);  chk("R1 off read-back after reset", v, 32'h0);
      rd(A_EN, v);   chk("R1 enabled after reset", v, 32'h0);
      rd(A_DONE, v); chk("R1 idle after reset", v, 32'hF);
      rd(A_SSTA, v); chk("R1 on-pending after reset", v, 32'h0);
      rd(A_CSTA, v); chk("R1 off-pending after reset", v, 32'h0);
      rd(A_ERR, v);  chk("R1 error after reset", v, 32'h0);
      chk("R1 switch request after reset", 32'(sw_req), 32'h0);

      // Vector walk: R2 bit mapping checked through the exact enabled pattern
      cur_en = 4'b0000;
      for (int i = 0; i < NVEC; i++) begin
         do_cmd(VEC_CMD[i][4], VEC_CMD[i][3:0], cur_en, VEC_EN[i]);
         cur_en = VEC_EN[i];
      end
      rd(A_ERR, v); chk("R2 no error after legal votes", v, 32'h0);

      // R11 mixed accept and reject in one write
      wr(A_SET, 32'h2);
      wr(A_SET, 32'hA);
      rd(A_ERR, v);  chk("R11 busy domain flagged only", v, 32'h2);
      rd(A_SSTA, v); chk("R11 idle domain accepted", 32'(v[3:0] & 4'hA), 32'hA);
      wait_idle(4'hA, "R11 both domains finished");
      rd(A_EN, v);   chk("R11 enabled pattern", v, 32'hA);

      // R9 vote during running power-off is ignored
      wr(A_CLR, 32'h2);
      wr(A_SET, 32'h2);
      rd(A_ERR, v);  chk("R9 sticky error held", v, 32'h2);
      wait_idle(4'h2, "R9 power-off finished");
      rd(A_EN, v);   chk("R9 rejected vote had no effect", v, 32'h8);
      chk("R9 request follows original command", 32'(sw_req), 32'h8);
      rd(A_SSTA, v); chk("R9 no power-on pending", v, 32'h0);
      rd(A_ERR, v);  chk("R9 error still set", v, 32'h2);

      // R2 unused bits and offsets read zero
      rd(7, v);      chk("R2 unused offset reads zero", v, 32'h0);

      // R1 reset clears sticky error
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      rd(A_ERR, v);  chk("R1 error cleared by reset", v, 32'h0);
      rd(A_EN, v);   chk("R1 enabled cleared by reset", v, 32'h0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule